// File: doc/BRIEF.md
# Instruction Cache Line Parity Generator and Checker

This block protects one instruction cache line with parity. On the fill side it turns the incoming tag and eight instruction words into ten check bits, which the cache arrays store beside the line. The tag gets two check bits: one over its even-numbered bits and one over its odd-numbered bits. Because of this split, an upset that flips two neighbouring tag bits is still seen. Each word gets one bit. Stored parity is even, so a check bit is the XOR of the bits it covers.

On the fetch side the block takes the tag, the one fetched word and their stored check bits as read back from the arrays. It recomputes parity. Any odd result is reported as a parity machine-check. The report has two parts: a one-cycle pulse, and a sticky syndrome with one bit per protected field. Software clears the syndrome by writing ones to the bits it wants cleared.

Two injection masks let software store odd parity on purpose, so that the error path can be exercised. One mask has a bit per tag half, the other a bit per word. Every line filled while a mask bit is set is affected.

Top module: `line_parity_guard`

## Requirements
- R1: `fill_word_par[i]` is the XOR of `fill_data[32*i+31:32*i]` and `inj_word_mask[i]`, so each word's check bit is even parity unless its injection bit is set.
- R2: `fill_tag_par[0]` is the XOR of the tag bits at even indices and `inj_tag_mask[0]`. `fill_tag_par[1]` is the XOR of the tag bits at odd indices and `inj_tag_mask[1]`.
- R3: Injection acts on every fill presented while a mask bit is set. Fills presented after the mask returns to zero get normal even parity.
- R4: On a cycle with `fetch_valid` high, suppose `rd_word` together with `rd_word_par` holds an odd number of ones. Then on the next cycle `mchk_pulse` is 1 and syndrome bit `2+fetch_word_sel` is set. No other word's bit is set by that fetch.
- R5: A tag half is checked only on a fetch cycle with `fetch_tag_chk` high. An odd even-index half sets syndrome bit 0, and an odd odd-index half sets syndrome bit 1. With `fetch_tag_chk` low, a bad tag raises nothing.
- R6: An upset that flips two adjacent tag bits is detected, and it sets both syndrome bits 0 and 1.
- R7: `mchk_pulse` is high in the cycle after a fetch that found at least one error, and low in every other cycle.
- R8: The syndrome is sticky. Bits accumulate across erroneous fetches and stay set until cleared.
- R9: A cycle with `synd_clr_wr` high clears the syndrome bits selected by `synd_clr_mask`. An error detected in the same cycle sets its bit anyway, so setting wins over clearing.
- R10: While `rst_n` is low, `mchk_pulse` and `syndrome` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_tag_mask | input | 2 | Tag parity injection (bit 0 even half, bit 1 odd half) |
| inj_word_mask | input | 8 | Word parity injection, bit i for word i |
| fill_tag | input | TAG_W | Tag of the line being filled |
| fill_data | input | 256 | Eight words of the line being filled, word i at bits 32i+31:32i |
| fill_tag_par | output | 2 | Tag check bits to store |
| fill_word_par | output | 8 | Word check bits to store |
| fetch_valid | input | 1 | A fetch read is presented this cycle |
| fetch_tag_chk | input | 1 | The tag compare is used by this fetch |
| fetch_word_sel | input | 3 | Index of the fetched word |
| rd_tag | input | TAG_W | Stored tag read back |
| rd_tag_par | input | 2 | Stored tag check bits |
| rd_word | input | 32 | Fetched word read back |
| rd_word_par | input | 1 | Stored check bit of the fetched word |
| synd_clr_wr | input | 1 | Syndrome clear write strobe |
| synd_clr_mask | input | 10 | Bits to clear (1 clears) |
| mchk_pulse | output | 1 | One-cycle parity machine-check indication |
| syndrome | output | 10 | Sticky error record: bit 0 tag even half, bit 1 tag odd half, bit 2+i word i |

## Verification
The fill side is tried in several ways:
- All-zero, all-one, walking-one and pseudo-random lines, which show whether each word and each tag half is folded over the right bits.
- Each injection mask bit set alone and then cleared, which shows whether injection reaches exactly one check bit and stops when released.

The fetch side is tried with several cases:
- Clean reads, which must stay silent.
- Single-bit corruption of each word index, which shows whether the syndrome position follows the selected word.
- A bad tag with and without the tag-use qualifier, which shows whether tag checking is gated.
- A two-adjacent-bit tag upset, which must light both tag bits.

Back-to-back errors, partial clears, and a clear that coincides with a new error separate accumulation, clearing and their priority.

// File: rtl/line_parity_guard.sv
module line_parity_guard #(
  parameter int TAG_W  = 21,
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter int SEL_W  = $clog2(WORDS),
  parameter int SYN_W  = WORDS + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              inj_tag_mask,
  input  logic [WORDS-1:0]        inj_word_mask,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WORDS*WORD_W-1:0] fill_data,
  output logic [1:0]              fill_tag_par,
  output logic [WORDS-1:0]        fill_word_par,
  input  logic                    fetch_valid,
  input  logic                    fetch_tag_chk,
  input  logic [SEL_W-1:0]        fetch_word_sel,
  input  logic [TAG_W-1:0]        rd_tag,
  input  logic [1:0]              rd_tag_par,
  input  logic [WORD_W-1:0]       rd_word,
  input  logic                    rd_word_par,
  input  logic                    synd_clr_wr,
  input  logic [SYN_W-1:0]        synd_clr_mask,
  output logic                    mchk_pulse,
  output logic [SYN_W-1:0]        syndrome
);

  function automatic logic [TAG_W-1:0] even_sel();
    logic [TAG_W-1:0] m;
    m = '0;
    for (int i = 0; i < TAG_W; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [TAG_W-1:0] EVEN_M = even_sel();
  localparam logic [TAG_W-1:0] ODD_M  = ~EVEN_M;

  assign fill_tag_par[0] = ^(fill_tag & EVEN_M) ^ inj_tag_mask[0];
  assign fill_tag_par[1] = ^(fill_tag & ODD_M)  ^ inj_tag_mask[1];

  for (genvar w = 0; w < WORDS; w++) begin : g_fill
    assign fill_word_par[w] = ^fill_data[w*WORD_W +: WORD_W] ^ inj_word_mask[w];
  end

  logic [1:0]       tag_err;
  logic             word_err;
  logic [SYN_W-1:0] err_vec;

  assign tag_err[0] = fetch_valid & fetch_tag_chk & (^(rd_tag & EVEN_M) ^ rd_tag_par[0]);
  assign tag_err[1] = fetch_valid & fetch_tag_chk & (^(rd_tag & ODD_M)  ^ rd_tag_par[1]);
  assign word_err   = fetch_valid & (^rd_word ^ rd_word_par);

  always_comb begin
    err_vec = '0;
    err_vec[1:0] = tag_err;
    err_vec[int'(fetch_word_sel) + 2] = word_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mchk_pulse <= 1'b0;
      syndrome   <= '0;
    end else begin
      mchk_pulse <= |err_vec;
      syndrome   <= (syndrome & ~(synd_clr_wr ? synd_clr_mask : '0)) | err_vec;
    end
  end

  // R1
  word_par_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_word_mask == '0) |-> ((^fill_data) == (^fill_word_par)));

  // R2
  tag_par_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_tag_mask == 2'b00) |-> ((^fill_tag) == (^fill_tag_par)));

  // R7
  quiet_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !mchk_pulse);

  // R7
  pulse_has_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_pulse |-> (syndrome != '0));

  // R5
  tag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid || !fetch_tag_chk) |=> ((syndrome[1:0] & ~$past(syndrome[1:0])) == 2'b00));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !synd_clr_wr |=> ((syndrome & $past(syndrome)) == $past(syndrome)));

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (synd_clr_wr && !fetch_valid) |=> ((syndrome & $past(synd_clr_mask)) == '0));

endmodule

// File: tb/line_parity_guard_tb_top.sv
`timescale 1ns/1ps
module line_parity_guard_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0]   inj_tag_mask = '0;
  logic [7:0]   inj_word_mask = '0;
  logic [20:0]  fill_tag = '0;
  logic [255:0] fill_data = '0;
  logic [1:0]   fill_tag_par;
  logic [7:0]   fill_word_par;
  logic         fetch_valid = 0, fetch_tag_chk = 0;
  logic [2:0]   fetch_word_sel = '0;
  logic [20:0]  rd_tag = '0;
  logic [1:0]   rd_tag_par = '0;
  logic [31:0]  rd_word = '0;
  logic         rd_word_par = 0;
  logic         synd_clr_wr = 0;
  logic [9:0]   synd_clr_mask = '0;
  logic         mchk_pulse;
  logic [9:0]   syndrome;

  always #10 clk = ~clk;

  line_parity_guard dut_i (.*);

  int checks = 0, failures = 0;
  string req = "R10";
  bit done = 0;
  bit exp_pulse = 0;
  bit [9:0] exp_synd = 0;

  function automatic bit odd32(logic [31:0] w);
    int n = 0;
    for (int i = 0; i < 32; i++) n += w[i];
    return bit'(n % 2);
  endfunction

  function automatic bit odd_half(logic [20:0] t, int start);
    int n = 0;
    for (int i = start; i < 21; i += 2) n += t[i];
    return bit'(n % 2);
  endfunction

  // reference model
  always @(posedge clk) begin
    bit [9:0] e;
    e = 0;
    if (!rst_n) begin
      exp_pulse <= 0;
      exp_synd  <= 0;
    end else begin
      if (fetch_valid) begin
        if (fetch_tag_chk) begin
          e[0] = odd_half(rd_tag, 0) ^ rd_tag_par[0];
          e[1] = odd_half(rd_tag, 1) ^ rd_tag_par[1];
        end
        if (odd32(rd_word) ^ rd_word_par) e[fetch_word_sel + 2] = 1;
      end
      exp_pulse <= (e != 0);
      exp_synd  <= (exp_synd & ~(synd_clr_wr ? synd_clr_mask : 10'd0)) | e;
    end
  end

  task automatic chk(string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h @%0t", req, what, got, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #5;
      if (done) break;
      begin
        bit [7:0] wp; bit [1:0] tp;
        for (int w = 0; w < 8; w++) wp[w] = odd32(fill_data[w*32 +: 32]) ^ inj_word_mask[w];
        tp[0] = odd_half(fill_tag, 0) ^ inj_tag_mask[0];
        tp[1] = odd_half(fill_tag, 1) ^ inj_tag_mask[1];
        chk("mchk_pulse (R7)", 16'(mchk_pulse), 16'(exp_pulse));
        chk("syndrome (R8)", 16'(syndrome), 16'(exp_synd));
        chk("fill_word_par (R1)", 16'(fill_word_par), 16'(wp));
        chk("fill_tag_par (R2)", 16'(fill_tag_par), 16'(tp));
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic fill(logic [20:0] t, logic [255:0] d);
    tick(); fill_tag = t; fill_data = d;
  endtask

  // fetch of a word with its correct stored parity, optionally one bit flipped
  task automatic fetch(logic [2:0] sel, logic [31:0] w, bit flip_w,
                       bit tchk, logic [20:0] t, logic [20:0] tflip);
    tick();
    fetch_valid = 1; fetch_tag_chk = tchk; fetch_word_sel = sel;
    rd_word = w ^ (flip_w ? 32'h0000_0100 : 32'h0); rd_word_par = odd32(w);
    rd_tag = t ^ tflip; rd_tag_par = {odd_half(t, 1), odd_half(t, 0)};
  endtask

  task automatic idle();
    tick(); fetch_valid = 0; fetch_tag_chk = 0; synd_clr_wr = 0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    req = "R10";
    repeat (3) tick();
    rst_n = 1;
    req = "R1";
    fill(21'h0, '0);
    fill(21'h1F_FFFF, '1);
    for (int i = 0; i < 8; i++) fill(21'h0, 256'(1) << (i * 33));
    fill(21'h0, {8{$urandom()}} ^ {$urandom(), $urandom(), $urandom(), $urandom(),
                                   $urandom(), $urandom(), $urandom(), $urandom()});
    req = "R2";
    for (int i = 0; i < 21; i++) fill(21'(1) << i, '0);
    fill(21'h15_5555, '0);
    fill(21'h0A_AAAA, '0);
    req = "R3";
    for (int i = 0; i < 8; i++) begin
      tick(); inj_word_mask = 8'(1) << i;
      fill(21'h12345, {8{32'hDEAD_BEEF}});
    end
    tick(); inj_tag_mask = 2'b01; fill(21'h0ABCD, '0);
    tick(); inj_tag_mask = 2'b10; fill(21'h0ABCD, '1);
    tick(); inj_tag_mask = 2'b00; inj_word_mask = 8'h00;
    fill(21'h12345, {8{32'hDEAD_BEEF}});
    fill(21'h0ABCD, '1);

    req = "R4";
    for (int i = 0; i < 8; i++) fetch(3'(i), 32'hCAFE_0000 + i, 0, 1, 21'h1A2B3, 0);
    idle();
    for (int i = 0; i < 8; i++) begin
      fetch(3'(i), 32'h1357_9BDF ^ i, 1, 0, 21'h0, 0);
      idle();
      tick(); synd_clr_wr = 1; synd_clr_mask = '1;
      idle();
    end

    req = "R5";
    fetch(3'd0, 32'h1, 0, 0, 21'h0F0F0, 21'h1);
    idle();
    fetch(3'd0, 32'h1, 0, 1, 21'h0F0F0, 21'h1);
    idle();
    fetch(3'd0, 32'h1, 0, 1, 21'h0F0F0, 21'h2);
    idle();
    tick(); synd_clr_wr = 1; synd_clr_mask = '1;
    idle();

    req = "R6";
    fetch(3'd3, 32'h77, 0, 1, 21'h1F00F, 21'h30);
    idle();
    tick(); synd_clr_wr = 1; synd_clr_mask = '1;
    idle();

    req = "R7";
    fetch(3'd5, 32'hA5A5, 1, 0, 0, 0);
    fetch(3'd5, 32'hA5A5, 0, 0, 0, 0);
    fetch(3'd6, 32'hA5A5, 1, 0, 0, 0);
    idle(); idle();

    req = "R8";
    fetch(3'd1, 32'h9, 1, 0, 0, 0);
    fetch(3'd7, 32'h9, 1, 1, 21'h3, 21'h4);
    idle(); idle(); idle();

    req = "R9";
    tick(); synd_clr_wr = 1; synd_clr_mask = 10'b00_0000_1000;
    idle();
    fetch(3'd2, 32'h42, 1, 0, 0, 0); synd_clr_wr = 1; synd_clr_mask = '1;
    idle();
    tick(); synd_clr_wr = 1; synd_clr_mask = '1;
    idle(); idle();

    req = "R10";
    fetch(3'd4, 32'h5, 1, 0, 0, 0);
    tick(); rst_n = 0; fetch_valid = 0;
    idle(); idle();
    rst_n = 1;
    idle(); idle();

    done = 1;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule